// File: doc/BRIEF.md
# UART Buffer Status Flag Unit

This block connects a UART shift-register core to a CPU bus. It holds a one-byte receive holding buffer, a one-byte transmit holding buffer and a status register. The status register carries three flags: receive-full, transmit-empty and overrun. The core delivers each completed byte with a one-cycle strobe. The block loads the byte or records an overrun, and it pulses a receive interrupt. When the core is ready to send, it asks for the next byte with a load request. The block hands over the held byte and marks the transmit buffer empty again.

Software clears the flags with a two-step access. It first reads the status register, then reads or writes the matching data buffer. Each flag has its own armed latch. A status read arms a flag's latch only if that flag was set at that moment. The next access to the matching buffer clears only the flags whose latches were armed. So an overrun that appears after the status read survives the buffer read, and a later status read followed by another buffer read is needed to clear it. While overrun is set, the block accepts no new bytes.

Top module: `uart_bufstat`

## Requirements
- R1: After a synchronous reset, the status register reads transmit-empty = 1, receive-full = 0 and overrun = 0, all armed latches are cleared, and `rx_irq` and `tx_go` are low.
- R2: Register select `bus_addr` 0 is the status register (bit 0 receive-full, bit 1 transmit-empty, bit 2 overrun, all other bits 0). Address 1 is the receive buffer and address 2 is the transmit buffer, which reads back its held byte. Address 3 reads 0. `bus_rdata` follows `bus_addr` in the same cycle.
- R3: A `core_rx_valid` strobe that arrives while both receive-full and overrun are 0 loads `core_rx_byte` into the receive buffer and sets receive-full. `rx_irq` is high for exactly the one cycle after the strobe.
- R4: Receive-full clears only on a receive-buffer read that follows a status read which saw it set. A receive-buffer read without such a status read leaves it set.
- R5: A strobe that arrives while receive-full is 1 and overrun is 0 sets overrun and pulses `rx_irq`. The receive buffer keeps its old byte.
- R6: While overrun is 1, a strobe is ignored: the buffer is not loaded, receive-full does not change and `rx_irq` stays low. This holds even after receive-full has cleared.
- R7: Overrun clears on a receive-buffer read that follows a status read which saw it set. If overrun is set after the status read, the receive-buffer read leaves it set.
- R8: A `core_tx_load` request while transmit-empty is 0 puts the held byte on `core_tx_byte`, pulses `tx_go` for one cycle and sets transmit-empty, all in the cycle after the request. A request while transmit-empty is 1 is ignored.
- R9: A transmit-buffer write always stores `bus_wdata`. It clears transmit-empty only when a status read before it saw transmit-empty set.
- R10: Accesses to other registers between a status read and a buffer access leave the armed latches in place. A new status read re-samples every latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Bus read strobe, one cycle per access |
| bus_wr | input | 1 | Bus write strobe, one cycle per access |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| core_rx_valid | input | 1 | Received byte complete, one-cycle strobe |
| core_rx_byte | input | DATA_W | Received byte from the shift register |
| core_tx_load | input | 1 | Core asks for the next byte to send |
| core_tx_byte | output | DATA_W | Byte handed to the transmit shift register |
| tx_go | output | 1 | One-cycle pulse: `core_tx_byte` is valid and sending starts |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
Flag and buffer changes caused by a strobe, a load request or a bus access are due one edge later. `bus_rdata` responds within the same cycle as its address, so each read vector checks it a short delay after driving, before the next edge. The `rx_irq` and `tx_go` pulses, and the byte on `core_tx_byte`, are due in the cycle after their stimulus. Each vector's expected pulse is therefore checked at the falling edge that follows it, before the next vector is driven. The vector order deliberately places the strobe that causes an overrun between a status read and a buffer read, and places register accesses of other kinds between status reads and the accesses that clear flags.

// File: rtl/uart_bufstat_pkg.sv
package uart_bufstat_pkg;

    localparam int unsigned ADDR_W = 2;

    // Flag positions inside the status byte.
    localparam int unsigned RXF_POS = 0;
    localparam int unsigned TXE_POS = 1;
    localparam int unsigned OVR_POS = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_RXBUF  = 2'd1,
        SEL_TXBUF  = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic stat_rd;
        logic rxb_rd;
        logic txb_wr;
    } bus_evt_t;

    typedef struct packed {
        logic ovr;
        logic txe;
        logic rxf;
    } flags_t;

    function automatic bus_evt_t decode_access(logic rd, logic wr, logic [ADDR_W-1:0] addr);
        bus_evt_t ev;
        ev.stat_rd = rd && (reg_sel_e'(addr) == SEL_STATUS);
        ev.rxb_rd  = rd && (reg_sel_e'(addr) == SEL_RXBUF);
        ev.txb_wr  = wr && (reg_sel_e'(addr) == SEL_TXBUF);
        return ev;
    endfunction

endpackage

// File: rtl/uart_bufstat_bus.sv
module uart_bufstat_bus
    import uart_bufstat_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  flags_t            flags,
    input  logic [DATA_W-1:0] rx_buf,
    input  logic [DATA_W-1:0] tx_buf,
    output bus_evt_t          ev,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned PAD_W = DATA_W - 3;

    logic [DATA_W-1:0] status_word;

    always_comb begin
        status_word          = '0;
        status_word[RXF_POS] = flags.rxf;
        status_word[TXE_POS] = flags.txe;
        status_word[OVR_POS] = flags.ovr;
    end

    assign ev = decode_access(rd, wr, addr);

    always_comb begin
        unique case (reg_sel_e'(addr))
            SEL_STATUS: rdata = status_word;
            SEL_RXBUF:  rdata = rx_buf;
            SEL_TXBUF:  rdata = tx_buf;
            default:    rdata = '0;
        endcase
    end

    // R2
    status_pad_chk: assert final (PAD_W == 0 || status_word[DATA_W-1:3] == '0);

endmodule

// File: rtl/uart_bufstat_rx.sv
module uart_bufstat_rx #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_rd,
    input  logic              rxb_rd,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [DATA_W-1:0] rx_buf,
    output logic              rx_full,
    output logic              rx_ovr,
    output logic              rx_irq
);
    logic armed_rxf, armed_ovr;
    logic take, overrun, clr_rxf, clr_ovr;

    always_comb begin
        take    = rx_valid && !rx_ovr && !rx_full;
        overrun = rx_valid && !rx_ovr &&  rx_full;
        clr_rxf = rxb_rd && armed_rxf;
        clr_ovr = rxb_rd && armed_ovr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_buf    <= '0;
            rx_full   <= 1'b0;
            rx_ovr    <= 1'b0;
            rx_irq    <= 1'b0;
            armed_rxf <= 1'b0;
            armed_ovr <= 1'b0;
        end else begin
            if (stat_rd) begin
                armed_rxf <= rx_full;
                armed_ovr <= rx_ovr;
            end else if (rxb_rd) begin
                armed_rxf <= 1'b0;
                armed_ovr <= 1'b0;
            end
            if (take) rx_buf <= rx_byte;
            rx_full <= take || (rx_full && !clr_rxf);
            rx_ovr  <= overrun || (rx_ovr && !clr_ovr);
            rx_irq  <= take || overrun;
        end
    end

    // R3
    rx_irq_due_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ovr) |=> rx_irq);

    // R4
    rxf_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_full) |-> $past(rxb_rd));

    // R6
    ovr_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_ovr && rx_valid) |=> ($stable(rx_buf) && !rx_irq));

    // R7
    ovr_survive_chk: assert property (@(posedge clk) disable iff (rst)
        (rxb_rd && !armed_ovr && rx_ovr) |=> rx_ovr);

endmodule

// File: rtl/uart_bufstat_tx.sv
module uart_bufstat_tx #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_rd,
    input  logic              txb_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_load,
    output logic [DATA_W-1:0] tx_buf,
    output logic              tx_empty,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_go
);
    logic armed_txe;
    logic accept, clr_txe;

    always_comb begin
        accept  = tx_load && !tx_empty;
        clr_txe = txb_wr && armed_txe;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_buf    <= '0;
            tx_empty  <= 1'b1;
            tx_byte   <= '0;
            tx_go     <= 1'b0;
            armed_txe <= 1'b0;
        end else begin
            if (stat_rd)     armed_txe <= tx_empty;
            else if (txb_wr) armed_txe <= 1'b0;
            if (txb_wr) tx_buf  <= wdata;
            if (accept) tx_byte <= tx_buf;
            tx_empty <= accept || (tx_empty && !clr_txe);
            tx_go    <= accept;
        end
    end

    // R8
    tx_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_load && tx_empty) |=> !tx_go);

    // R8
    tx_empty_after_go_chk: assert property (@(posedge clk) disable iff (rst)
        tx_go |-> tx_empty);

    // R9
    txe_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_empty) |-> $past(txb_wr));

endmodule

// File: rtl/uart_bufstat.sv
module uart_bufstat
    import uart_bufstat_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              core_rx_valid,
    input  logic [DATA_W-1:0] core_rx_byte,
    input  logic              core_tx_load,
    output logic [DATA_W-1:0] core_tx_byte,
    output logic              tx_go,
    output logic              rx_irq
);
    bus_evt_t          ev;
    flags_t            flags;
    logic [DATA_W-1:0] rx_buf, tx_buf;
    logic              rx_full, rx_ovr, tx_empty;

    assign flags = '{ovr: rx_ovr, txe: tx_empty, rxf: rx_full};

    uart_bufstat_bus #(.DATA_W(DATA_W)) u_bus (
        .rd     (bus_rd),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .flags  (flags),
        .rx_buf (rx_buf),
        .tx_buf (tx_buf),
        .ev     (ev),
        .rdata  (bus_rdata)
    );

    uart_bufstat_rx #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .stat_rd  (ev.stat_rd),
        .rxb_rd   (ev.rxb_rd),
        .rx_valid (core_rx_valid),
        .rx_byte  (core_rx_byte),
        .rx_buf   (rx_buf),
        .rx_full  (rx_full),
        .rx_ovr   (rx_ovr),
        .rx_irq   (rx_irq)
    );

    uart_bufstat_tx #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .stat_rd  (ev.stat_rd),
        .txb_wr   (ev.txb_wr),
        .wdata    (bus_wdata),
        .tx_load  (core_tx_load),
        .tx_buf   (tx_buf),
        .tx_empty (tx_empty),
        .tx_byte  (core_tx_byte),
        .tx_go    (tx_go)
    );

    // R1
    reset_flags_chk: assert property (@(posedge clk)
        $past(rst) |-> (tx_empty && !rx_full && !rx_ovr && !rx_irq && !tx_go));

    // R5
    overrun_keeps_buf_chk: assert property (@(posedge clk) disable iff (rst)
        (core_rx_valid && rx_full && !rx_ovr) |=> (rx_ovr && rx_irq && $stable(rx_buf)));

endmodule

// File: tb/uart_bufstat_bench.sv
`timescale 1ns/1ps
module uart_bufstat_bench;
    localparam int DW = 8;
    // vector fields: op[24:22] data[21:14] expect[13:6] pulse{irq,go}[5:4] req[3:0]
    localparam logic [2:0] IDL = 3'd0, RXB = 3'd1, RDS = 3'd2, RDR = 3'd3,
                           RDT = 3'd4, WRT = 3'd5, LDT = 3'd6;
    localparam int NV = 37;
    localparam logic [24:0] VEC [NV] = '{
        {RDS, 8'h00, 8'h02, 2'b00, 4'd1},  // R1 reset status
        {RXB, 8'hA5, 8'h00, 2'b10, 4'd3},  // R3 load + irq
        {RDR, 8'h00, 8'hA5, 2'b00, 4'd4},  // R4 read without armed latch
        {RDS, 8'h00, 8'h03, 2'b00, 4'd4},  // R4 still full
        {RDR, 8'h00, 8'hA5, 2'b00, 4'd4},  // R4 clearing read
        {RDS, 8'h00, 8'h02, 2'b00, 4'd4},  // R4 cleared
        {RXB, 8'h3C, 8'h00, 2'b10, 4'd3},  // R3
        {RXB, 8'h77, 8'h00, 2'b10, 4'd5},  // R5 overrun irq
        {RDS, 8'h00, 8'h07, 2'b00, 4'd5},  // R5 flags
        {RDR, 8'h00, 8'h3C, 2'b00, 4'd5},  // R5 old byte kept
        {RDS, 8'h00, 8'h02, 2'b00, 4'd7},  // R7 both cleared
        {RXB, 8'h11, 8'h00, 2'b10, 4'd3},  // R3
        {RDS, 8'h00, 8'h03, 2'b00, 4'd7},  // R7 arms rxf only
        {RXB, 8'h22, 8'h00, 2'b10, 4'd5},  // R5 overrun inside sequence
        {RXB, 8'h33, 8'h00, 2'b00, 4'd6},  // R6 blocked, no irq
        {RDR, 8'h00, 8'h11, 2'b00, 4'd6},  // R6 buffer unchanged
        {RDS, 8'h00, 8'h06, 2'b00, 4'd7},  // R7 overrun survived
        {RXB, 8'h44, 8'h00, 2'b00, 4'd6},  // R6 blocked with rxf 0
        {RDS, 8'h00, 8'h06, 2'b00, 4'd6},  // R6 no load
        {RDR, 8'h00, 8'h11, 2'b00, 4'd7},  // R7 clearing read
        {RDS, 8'h00, 8'h02, 2'b00, 4'd7},  // R7 cleared
        {LDT, 8'h00, 8'h00, 2'b00, 4'd8},  // R8 ignored when empty
        {WRT, 8'h5A, 8'h00, 2'b00, 4'd9},  // R9 armed write
        {RDS, 8'h00, 8'h00, 2'b00, 4'd9},  // R9 txe cleared
        {RDT, 8'h00, 8'h5A, 2'b00, 4'd2},  // R2 tx readback
        {LDT, 8'h00, 8'h5A, 2'b01, 4'd8},  // R8 hand-off
        {RDS, 8'h00, 8'h02, 2'b00, 4'd8},  // R8 txe set
        {RXB, 8'h9E, 8'h00, 2'b10, 4'd10}, // R10 other access
        {RDR, 8'h00, 8'h9E, 2'b00, 4'd10}, // R10 rxf not armed
        {WRT, 8'h81, 8'h00, 2'b00, 4'd10}, // R10 txe latch kept
        {RDS, 8'h00, 8'h01, 2'b00, 4'd10}, // R10
        {WRT, 8'h90, 8'h00, 2'b00, 4'd10}, // R10 write between
        {RDR, 8'h00, 8'h9E, 2'b00, 4'd10}, // R10 rxf clears
        {RDS, 8'h00, 8'h00, 2'b00, 4'd10}, // R10
        {RDT, 8'h00, 8'h90, 2'b00, 4'd2},  // R2
        {LDT, 8'h00, 8'h90, 2'b01, 4'd8},  // R8
        {IDL, 8'h00, 8'h00, 2'b00, 4'd8}   // R8 flush
    };

    logic clk = 0, rst = 1;
    logic bus_rd = 0, bus_wr = 0;
    logic [1:0] bus_addr = 0;
    logic [DW-1:0] bus_wdata = 0, bus_rdata, core_rx_byte = 0, core_tx_byte;
    logic core_rx_valid = 0, core_tx_load = 0, tx_go, rx_irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_bufstat #(.DATA_W(DW)) u_uart_bufstat (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_rx_valid(core_rx_valid),
        .core_rx_byte(core_rx_byte), .core_tx_load(core_tx_load),
        .core_tx_byte(core_tx_byte), .tx_go(tx_go), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        core_rx_valid = 0; core_rx_byte = 0; core_tx_load = 0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] prev_pulse;
        logic [7:0] prev_exp;
        string      prev_req;
        prev_pulse = 0; prev_exp = 0; prev_req = "R1";
        repeat (3) @(negedge clk);
        rst = 0;
        for (int i = 0; i < NV; i++) begin
            logic [2:0] op;
            logic [7:0] d, e;
            string r;
            op = VEC[i][24:22]; d = VEC[i][21:14]; e = VEC[i][13:6];
            r  = $sformatf("R%0d", VEC[i][3:0]);
            @(negedge clk);
            chk({prev_req, " pulses"}, {6'b0, rx_irq, tx_go}, {6'b0, prev_pulse});
            if (prev_pulse[0]) chk({prev_req, " tx byte"}, core_tx_byte, prev_exp);
            idle_inputs();
            case (op)
                RXB: begin core_rx_valid = 1; core_rx_byte = d; end
                RDS: begin bus_rd = 1; bus_addr = 2'd0; end
                RDR: begin bus_rd = 1; bus_addr = 2'd1; end
                RDT: begin bus_rd = 1; bus_addr = 2'd2; end
                WRT: begin bus_wr = 1; bus_addr = 2'd2; bus_wdata = d; end
                LDT: core_tx_load = 1;
                default: ;
            endcase
            #1;
            if (op == RDS || op == RDR || op == RDT) chk({r, " read"}, bus_rdata, e);
            prev_pulse = VEC[i][5:4]; prev_exp = e; prev_req = r;
        end

        // Directed: reset state after activity (R1)
        @(negedge clk); idle_inputs(); rst = 1;
        repeat (2) @(negedge clk);
        rst = 0; #1;
        chk("R1 status", bus_rdata, 8'h02);
        chk("R1 pulses", {6'b0, rx_irq, tx_go}, 8'h00);
        // R9: write with no prior status read keeps txe set
        @(negedge clk); bus_wr = 1; bus_addr = 2'd2; bus_wdata = 8'hEE;
        @(negedge clk); idle_inputs(); #1;
        chk("R9 txe kept", bus_rdata, 8'h02);
        bus_addr = 2'd2; #1;
        chk("R9 data stored", bus_rdata, 8'hEE);
        bus_addr = 2'd3; #1;
        chk("R2 spare reads zero", bus_rdata, 8'h00);
        // R8: load while txe set is ignored
        @(negedge clk); core_tx_load = 1;
        @(negedge clk); idle_inputs();
        chk("R8 ignored load", {7'b0, tx_go}, 8'h00);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end
endmodule